// File: doc/BRIEF.md
# Fast page-mode DRAM controller

This block runs an external DRAM that has a 4-bit data path and one shared 12-bit address bus. It places the row address on that bus and pulls RAS low. It then places each column address on the bus and strobes CAS, once for every access. After one activation, a run of reads and writes can stay in the same row. The row is closed only when the requester stops flagging continuation, when the next request targets another row, or when a refresh is due. Refresh uses CAS-before-RAS cycles. A free-running interval counter marks them due, and the interval is set so that every row is refreshed within 20 ms.

The user side is a valid/ready request channel. A request carries a row, a column, a write flag, write data and a continue flag. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. After the requester raises `req_valid`, it must hold the request fields steady until that edge. `req_ready` is high only when no refresh is pending and one of two conditions holds:
- the controller is idle, or
- a page is open and `req_row` equals the open row.

A request for another row while a page is open makes the controller close the page first, with `req_ready` held low. Read data comes back on `rd_valid`/`rd_data` as a one-cycle pulse, in request order, with no back-pressure. Every timing phase is a parameter counted in system-clock cycles.

Top module: `pmd_ctrl`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, `dram_dq_oe` is 0, `rd_valid` is 0, and `req_ready` is 1.
- R2: The row address is on `dram_addr` for at least one cycle before RAS falls. The column address is on `dram_addr` for at least one cycle before each CAS fall.
- R3: For every column access, CAS stays low for exactly `P_CAS` cycles. Between two column accesses in the same page, CAS stays high for at least `P_CP` cycles.
- R4: A write drives `dram_we_n` low and `dram_dq_oe` high, with the request's data on `dram_dq_out`, from the setup cycle through the whole CAS-low time. A read keeps `dram_we_n` high and `dram_dq_oe` low.
- R5: A read returns the `dram_dq_in` value that was present in its last CAS-low cycle, as a `rd_valid` pulse one cycle wide. Reads return in request order.
- R6: When an access was issued with continue set, and the next accepted request hits the same row, the next access reuses the open row. RAS does not rise between the two accesses unless a refresh came between them.
- R7: When the previous access had continue clear, or the next request targets another row, RAS rises and stays high for at least `P_RP` cycles before the next activation.
- R8: Every RAS-low period, including a refresh, lasts at least `P_RAS_MIN` cycles.
- R9: Refresh is a CAS-before-RAS cycle with `dram_we_n` high. One refresh becomes due every `P_REF_INT` cycles.
- R10: A due refresh comes before any waiting request. An open page is closed for it, and the refresh starts within a bounded number of cycles of becoming due, however long a burst the requester keeps up.
- R11: While RAS is low, no request is accepted unless its row equals the open row, and no request is accepted while CAS is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge when valid is also high |
| req_row | input | P_ADDR_W | Row address |
| req_col | input | P_ADDR_W | Column address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | P_DATA_W | Write data |
| req_cont | input | 1 | Keep the page open for a following same-row request |
| rd_valid | output | 1 | Read data valid, one-cycle pulse |
| rd_data | output | P_DATA_W | Read data |
| dram_addr | output | P_ADDR_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | P_DATA_W | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | P_DATA_W | Data returned by the DRAM |

## Verification
The bench writes every column of four rows and reads them back, using three request patterns:
- Continued same-row bursts must share one activation.
- Single accesses must open a new row each time.
- Accesses that are flagged as continued but alternate rows must still close and reopen the page, because the row check alone decides.

An inline DRAM model measures each strobe phase against its parameter and keeps its own memory, so a wrong column, a wrong write or a wrong capture cycle shows up as a read mismatch. Bursts that last several refresh intervals, followed by an idle stretch with a page left open, show whether refresh waits behind requests or is served promptly in both situations.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

  typedef enum logic [3:0] {
    S_IDLE,   // RAS high, nothing pending
    S_RSET,   // row address set up, RAS still high
    S_ROW,    // RAS low, row-to-column delay
    S_CSET,   // column address set up, CAS high
    S_CAS,    // CAS low
    S_CP,     // CAS precharge inside the page
    S_OPEN,   // page open, waiting for a same-row request
    S_CLOSE,  // waiting for RAS minimum low time
    S_RP,     // RAS precharge
    S_RFC,    // refresh: CAS low ahead of RAS
    S_RFR     // refresh: CAS and RAS low
  } pmd_state_e;

  function automatic int pmd_max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/pmd_refresh_timer.sv
module pmd_refresh_timer #(
  parameter int P_INTERVAL = 1220
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pending
);
  localparam int W = $clog2(P_INTERVAL + 1);

  logic [W-1:0] cnt;
  logic         tick;

  assign tick = (cnt == W'(P_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/pmd_ras_timer.sv
module pmd_ras_timer #(
  parameter int P_MIN = 70
) (
  input  logic clk,
  input  logic rst,
  input  logic ras_low,
  output logic min_met
);
  localparam int W = $clog2(P_MIN + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !ras_low) cnt <= '0;
    else if (cnt < W'(P_MIN - 1)) cnt <= cnt + 1'b1;
  end

  // true in the cycle that completes P_MIN low cycles
  assign min_met = ras_low && (cnt >= W'(P_MIN - 1));
endmodule

// File: rtl/pmd_ctrl.sv
module pmd_ctrl #(
  parameter int P_ADDR_W  = 12,
  parameter int P_DATA_W  = 4,
  parameter int P_RCD     = 7,    // RAS low before column setup
  parameter int P_CAS     = 52,   // CAS low cycles (also covers WE low time)
  parameter int P_CP      = 53,   // CAS high cycles between column strobes
  parameter int P_RP      = 35,   // RAS precharge cycles
  parameter int P_RAS_MIN = 70,   // minimum RAS low cycles
  parameter int P_REF_INT = 1220  // cycles between refreshes (20 ms / 4096 rows at 4 ns)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [P_ADDR_W-1:0] req_row,
  input  logic [P_ADDR_W-1:0] req_col,
  input  logic                req_wr,
  input  logic [P_DATA_W-1:0] req_wdata,
  input  logic                req_cont,
  output logic                rd_valid,
  output logic [P_DATA_W-1:0] rd_data,
  output logic [P_ADDR_W-1:0] dram_addr,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic [P_DATA_W-1:0] dram_dq_out,
  output logic                dram_dq_oe,
  input  logic [P_DATA_W-1:0] dram_dq_in
);
  import pmd_pkg::*;

  localparam int CMAX = pmd_max4(P_RCD, P_CAS, P_CP, P_RP);
  localparam int CW   = $clog2(CMAX + 1);

  pmd_state_e          state;
  logic [CW-1:0]       cnt;
  logic                cnt_zero;
  logic [P_ADDR_W-1:0] row_q, col_q;
  logic                wr_q, cont_q;
  logic [P_DATA_W-1:0] wdata_q;
  logic                ref_pend, ref_ack, ras_ok, accept, row_hit;

  pmd_refresh_timer #(.P_INTERVAL(P_REF_INT)) u_ref (
    .clk(clk), .rst(rst), .ack(ref_ack), .pending(ref_pend)
  );

  pmd_ras_timer #(.P_MIN(P_RAS_MIN)) u_ras (
    .clk(clk), .rst(rst), .ras_low(!dram_ras_n), .min_met(ras_ok)
  );

  assign cnt_zero  = (cnt == '0);
  assign row_hit   = (req_row == row_q);
  assign req_ready = !ref_pend &&
                     ((state == S_IDLE) || (state == S_OPEN && row_hit));
  assign accept    = req_valid && req_ready;
  assign ref_ack   = (state == S_IDLE) && ref_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      row_q    <= '0;
      col_q    <= '0;
      wr_q     <= 1'b0;
      cont_q   <= 1'b0;
      wdata_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (!cnt_zero) cnt <= cnt - 1'b1;
      if (accept) begin
        row_q   <= req_row;
        col_q   <= req_col;
        wr_q    <= req_wr;
        wdata_q <= req_wdata;
        cont_q  <= req_cont;
      end
      unique case (state)
        S_IDLE: begin
          if (ref_pend)    state <= S_RFC;
          else if (accept) state <= S_RSET;
        end
        S_RSET: begin
          state <= S_ROW;
          cnt   <= CW'(P_RCD - 1);
        end
        S_ROW: if (cnt_zero) state <= S_CSET;
        S_CSET: begin
          state <= S_CAS;
          cnt   <= CW'(P_CAS - 1);
        end
        S_CAS: if (cnt_zero) begin
          if (!wr_q) begin
            rd_valid <= 1'b1;
            rd_data  <= dram_dq_in;
          end
          state <= S_CP;
          cnt   <= CW'(P_CP - 1);
        end
        S_CP: if (cnt_zero) state <= cont_q ? S_OPEN : S_CLOSE;
        S_OPEN: begin
          if (ref_pend)       state <= S_CLOSE;
          else if (accept)    state <= S_CSET;
          else if (req_valid) state <= S_CLOSE;
        end
        S_CLOSE, S_RFR: if (ras_ok) begin
          state <= S_RP;
          cnt   <= CW'(P_RP - 1);
        end
        S_RP: if (cnt_zero) state <= S_IDLE;
        S_RFC: state <= S_RFR;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    dram_ras_n = 1'b1;
    dram_cas_n = 1'b1;
    dram_addr  = row_q;
    case (state)
      S_ROW, S_OPEN, S_CLOSE: dram_ras_n = 1'b0;
      S_CSET, S_CP: begin
        dram_ras_n = 1'b0;
        dram_addr  = col_q;
      end
      S_CAS: begin
        dram_ras_n = 1'b0;
        dram_cas_n = 1'b0;
        dram_addr  = col_q;
      end
      S_RFC: dram_cas_n = 1'b0;
      S_RFR: begin
        dram_ras_n = 1'b0;
        dram_cas_n = 1'b0;
      end
      default: ;
    endcase
  end

  assign dram_dq_oe  = wr_q && (state == S_CSET || state == S_CAS);
  assign dram_we_n   = !(wr_q && (state == S_CSET || state == S_CAS));
  assign dram_dq_out = wdata_q;

endmodule

// File: rtl/pmd_ctrl_chk.sv
module pmd_ctrl_chk #(
  parameter int P_ADDR_W  = 12,
  parameter int P_CAS     = 52,
  parameter int P_RP      = 35,
  parameter int P_RAS_MIN = 70
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_ready,
  input logic                rd_valid,
  input logic [P_ADDR_W-1:0] dram_addr,
  input logic                dram_ras_n,
  input logic                dram_cas_n,
  input logic                dram_we_n
);
  logic [31:0] ras_lo, ras_hi, cas_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_lo <= '0;
      ras_hi <= 32'(P_RP);
      cas_lo <= '0;
    end else begin
      ras_lo <= dram_ras_n ? '0 : ((ras_lo == '1) ? ras_lo : ras_lo + 1);
      ras_hi <= !dram_ras_n ? '0 : ((ras_hi == '1) ? ras_hi : ras_hi + 1);
      cas_lo <= dram_cas_n ? '0 : ((cas_lo == '1) ? cas_lo : cas_lo + 1);
    end
  end

  a_r8_ras_min_low: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_ras_n) |-> (ras_lo >= 32'(P_RAS_MIN)));

  a_r7_ras_precharge: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> (ras_hi >= 32'(P_RP)));

  a_r3_cas_width: assert property (@(posedge clk) disable iff (rst)
    ($rose(dram_cas_n) && !dram_ras_n) |-> (cas_lo == 32'(P_CAS)));

  a_r2_col_addr_setup: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_ras_n) |-> $stable(dram_addr));

  a_r9_cbr_no_write: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_ras_n) && !dram_cas_n) |-> dram_we_n);

  a_r5_read_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  a_r11_no_accept_in_cas: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> dram_cas_n);

endmodule

bind pmd_ctrl pmd_ctrl_chk #(
  .P_ADDR_W(P_ADDR_W), .P_CAS(P_CAS), .P_RP(P_RP), .P_RAS_MIN(P_RAS_MIN)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
  .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n)
);

// File: tb/pmd_ctrl_tb.sv
`timescale 1ns/1ps
module pmd_ctrl_tb_top;
  localparam int AW = 12, DW = 4;
  localparam int RCD = 2, CASW = 3, CP = 2, RP = 3, RASMIN = 12, REFI = 150;
  localparam int LAT = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready, req_wr = 1'b0, req_cont = 1'b0;
  logic [AW-1:0] req_row = '0, req_col = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rd_valid;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [DW-1:0] dram_dq_out, dram_dq_in;

  always #2 clk = ~clk;

  pmd_ctrl #(.P_ADDR_W(AW), .P_DATA_W(DW), .P_RCD(RCD), .P_CAS(CASW), .P_CP(CP),
             .P_RP(RP), .P_RAS_MIN(RASMIN), .P_REF_INT(REFI)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_wr(req_wr), .req_wdata(req_wdata),
    .req_cont(req_cont), .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in));

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (!rst) cyc++;

  // ---------------- behavioural DRAM and pin monitor ----------------
  logic [3:0] mem    [0:255];
  logic [3:0] shadow [0:255];
  logic [AW-1:0] m_row = '0, m_col = '0;
  int m_act = 0, m_cbr = 0, ras_run = 0, cas_run = 0;
  bit seen_ras = 0, cas_in_page = 0, col_open = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  logic [AW-1:0] prev_addr = '0;

  int acc_row [0:511], acc_act [0:511], acc_cbr [0:511];
  bit acc_cont [0:511];
  int n_issued = 0, n_cas = 0;
  logic [3:0] exp_q [$];
  logic [3:0] w_data;

  assign dram_dq_in = (!dram_cas_n && !dram_ras_n && dram_we_n) ?
                      mem[{m_row[3:0], m_col[3:0]}] : 4'h0;

  always begin
    @(negedge clk);
    #1;
    if (!rst) begin
      // RAS edges
      if (prev_ras && !dram_ras_n) begin
        if (!dram_cas_n) begin
          m_cbr++;
          chk(dram_we_n, "R9 refresh with WE high", int'(dram_we_n), 1);
          chk(cyc >= m_cbr * REFI - 3 && cyc <= m_cbr * REFI + LAT,
              "R10 refresh start cycle", cyc, m_cbr * REFI);
        end else begin
          m_act++;
          m_row = dram_addr;
          chk(dram_addr == prev_addr, "R2 row addr setup", int'(dram_addr), int'(prev_addr));
          if (seen_ras) chk(ras_run >= RP, "R7 RAS precharge", ras_run, RP);
        end
        seen_ras = 1; cas_in_page = 0; ras_run = 1;
      end else if (!prev_ras && dram_ras_n) begin
        chk(ras_run >= RASMIN, "R8 RAS low time", ras_run, RASMIN);
        ras_run = 1;
      end else ras_run++;
      // CAS edges
      if (prev_cas && !dram_cas_n && !prev_ras) begin
        m_col = dram_addr;
        chk(dram_addr == prev_addr, "R2 col addr setup", int'(dram_addr), int'(prev_addr));
        if (cas_in_page) chk(cas_run >= CP, "R3 CAS high time", cas_run, CP);
        cas_in_page = 1; col_open = 1;
        if (!dram_we_n) begin
          w_data = dram_dq_out;
          mem[{m_row[3:0], m_col[3:0]}] = dram_dq_out;
        end else chk(!dram_dq_oe, "R4 read keeps bus off", int'(dram_dq_oe), 0);
        acc_act[n_cas] = m_act; acc_cbr[n_cas] = m_cbr; n_cas++;
        cas_run = 1;
      end else if (!prev_cas && dram_cas_n) begin
        if (col_open) chk(cas_run == CASW, "R3 CAS low time", cas_run, CASW);
        col_open = 0; cas_run = 1;
      end else if (prev_cas != dram_cas_n) cas_run = 1;
      else cas_run++;
      if (col_open && !dram_we_n)
        chk(dram_dq_oe && dram_dq_out == w_data, "R4 write data held",
            int'(dram_dq_out), int'(w_data));
      // request channel
      if (!dram_ras_n && req_valid && req_row != m_row)
        chk(!req_ready, "R11 ready on row miss", int'(req_ready), 0);
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(0, "R5 unexpected read", int'(rd_data), -1);
        else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R5 read data", int'(rd_data), int'(e));
        end
      end
      prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_addr = dram_addr;
    end
  end

  // ---------------- request driver ----------------
  task automatic issue(input int row, input int col, input bit wr,
                       input logic [3:0] d, input bit cont);
    @(negedge clk);
    req_valid = 1'b1; req_row = AW'(row); req_col = AW'(col);
    req_wr = wr; req_wdata = d; req_cont = cont;
    #0.5;
    while (!req_ready) begin @(negedge clk); #0.5; end
    @(posedge clk);
    acc_row[n_issued] = row; acc_cont[n_issued] = cont; n_issued++;
    if (wr) shadow[{row[3:0], col[3:0]}] = d;
    else exp_q.push_back(shadow[{row[3:0], col[3:0]}]);
  endtask

  task automatic go_idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 4'h0; shadow[i] = 4'h0; end
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle high",
        int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
    chk(!dram_dq_oe && !rd_valid, "R1 bus off, no read", int'({dram_dq_oe, rd_valid}), 0);
    chk(req_ready, "R1 ready after reset", int'(req_ready), 1);
    // Phase A: write every column of rows 0..3, two burst shapes
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 16; c++)
        issue(r, c, 1'b1, 4'((r * 5 + c * 3 + 1) % 16),
              (r % 2 == 1) ? 1'b1 : (c % 4 != 3));
    // Phase B: single reads of everything
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 16; c++)
        issue(r, c, 1'b0, 4'h0, 1'b0);
    // Phase C: continue flagged but rows alternate
    for (int i = 0; i < 32; i++)
      issue((i % 2 == 1) ? 1 : 2, i % 16, 1'b0, 4'h0, 1'b1);
    // Phase D: rewrite half of row 3, then a continued read burst left open
    for (int c = 0; c < 8; c++)
      issue(3, c, 1'b1, 4'(15 - c), c != 7);
    for (int c = 0; c < 16; c++)
      issue(3, c, 1'b0, 4'h0, 1'b1);
    go_idle();
    repeat (400) @(posedge clk);
    @(negedge clk);
    #1;
    chk(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 0);
    chk(n_cas == n_issued, "R6 one column strobe per request", n_cas, n_issued);
    for (int i = 1; i < n_cas && i < n_issued; i++) begin
      if (acc_cont[i-1] && acc_row[i] == acc_row[i-1]) begin
        if (acc_cbr[i] == acc_cbr[i-1])
          chk(acc_act[i] == acc_act[i-1], "R6 page kept open", acc_act[i], acc_act[i-1]);
        else
          chk(acc_act[i] != acc_act[i-1], "R10 refresh closed page", acc_act[i], acc_act[i-1] + 1);
      end else
        chk(acc_act[i] != acc_act[i-1], "R7 page closed", acc_act[i], acc_act[i-1] + 1);
    end
    chk(m_cbr >= cyc / REFI - 1 && m_cbr <= cyc / REFI, "R9 refresh count", m_cbr, cyc / REFI);
    chk(dram_ras_n, "R10 open page closed by refresh while idle", int'(dram_ras_n), 1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule